// File: doc/BRIEF.md
# DMA Address Translation Unit

This block sits on the inbound path of a host bridge and maps the 32-bit device-virtual addresses of bus-mastering devices, issued while the host is the target of a DMA read or write, onto 34-bit physical memory addresses. Pages are 8 KB. The low 13 bits of the address pass straight through, and the 19-bit virtual page number selects a translation.

Translations are held in a 16-slot fully associative cache. Every slot is compared with the incoming page number in the same cycle. A miss starts a hardware fetch of one 64-bit descriptor from a flat table in memory. There is no second level. The fetched descriptor is checked for validity and write permission. A good descriptor is placed in a free slot if one exists; otherwise a rotating pointer picks the slot. Only one fetch is in progress at a time, and new requests are held off until it finishes. A one-cycle invalidate pulse empties the cache.

Top module: `iova_xlate`

## Requirements
- R1: After reset, req_ready is high, rsp_valid and mem_req are low, and the cache holds no translations.
- R2: On a successful translation, rsp_paddr[12:0] equals req_vaddr[12:0] and rsp_paddr[33:13] equals descriptor bits [20:0].
- R3: A request that hits the cache gets its response in the cycle after acceptance and causes no memory read.
- R4: A miss reads the descriptor at cfg_tbl_base + 8 × (vpn AND (2^cfg_tbl_log2 − 1)), where vpn = req_vaddr[31:13]. Pages whose masked indices match share a descriptor.
- R5: Only one fetch is in progress at a time. req_ready is low from the cycle after a miss is accepted until the response, and the response comes in the cycle after mem_ack.
- R6: A descriptor with bit 63 (valid) clear gives rsp_fault high with rsp_paddr zero and is not cached, so the next access to that page reads memory again.
- R7: A write to a page whose descriptor has bit 62 (writable) clear faults. If the descriptor was fetched, it is not cached. A read of such a page succeeds.
- R8: Sixteen distinct pages can be resident together, and all of them then hit.
- R9: A fill uses the lowest free slot. When no slot is free, it uses a rotating victim pointer that starts at slot 0 and advances by one on each such replacement.
- R10: A cycle with inval_all high leaves every slot empty on the next cycle, so later accesses miss.
- R11: Every accepted request produces exactly one rsp_valid pulse, and rsp_valid never occurs without an accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Inbound DMA request present |
| req_ready | output | 1 | Request can be accepted |
| req_vaddr | input | 32 | Device-virtual address |
| req_write | input | 1 | 1 = DMA write, 0 = DMA read |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 34 | Physical address (zero on fault) |
| rsp_fault | output | 1 | Translation or permission fault |
| mem_req | output | 1 | Descriptor read request, held until acknowledged |
| mem_addr | output | 34 | Descriptor byte address |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_data | input | 64 | Descriptor word |
| cfg_tbl_base | input | 34 | Table base address (8-byte aligned) |
| cfg_tbl_log2 | input | 5 | log2 of the number of table entries |
| inval_all | input | 1 | Clear all cached translations |

## Verification
The checks assume that the configuration inputs stay constant while a fetch is in progress, that mem_ack comes only while mem_req is high, and that inval_all is not pulsed in the same cycle as a hit. The stimulus sets the table base and size once after reset. Its memory model acknowledges each read once, after a fixed latency, and never on its own. The invalidate pulse is driven only while no request is pending.

// File: rtl/iova_pkg.sv
package iova_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 34;
  localparam int PG_SH  = 13;
  localparam int VPN_W  = VA_W - PG_SH;
  localparam int PPN_W  = PA_W - PG_SH;
  localparam int DESC_W = 64;
  localparam int DESC_V = 63;
  localparam int DESC_W_BIT = 62;
  localparam int SZ_W   = 5;

  typedef enum logic {WK_IDLE, WK_FETCH} wk_state_e;
endpackage

// File: rtl/iova_cam.sv
module iova_cam
  import iova_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_wr,
  input  logic             fill_en,
  input  logic [IW-1:0]    fill_idx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_wr,
  input  logic             inval_all,
  output logic [N-1:0]     vld_o
);
  logic [N-1:0]     vld_q, vld_d, match;
  logic [VPN_W-1:0] tag_q [N];
  logic [PPN_W-1:0] ppn_q [N];
  logic [N-1:0]     wr_q;

  always_comb begin
    vld_d = vld_q;
    if (fill_en) vld_d[fill_idx] = 1'b1;
    if (inval_all) vld_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic load;
    assign load     = fill_en && (fill_idx == IW'(i));
    assign match[i] = vld_q[i] && (tag_q[i] == lk_vpn);
    always_ff @(posedge clk) begin
      if (load) begin
        tag_q[i] <= fill_vpn;
        ppn_q[i] <= fill_ppn;
        wr_q[i]  <= fill_wr;
      end
    end
  end

  always_comb begin
    lk_ppn = '0;
    lk_wr  = 1'b0;
    for (int i = 0; i < N; i++) begin
      lk_ppn = lk_ppn | ({PPN_W{match[i]}} & ppn_q[i]);
      lk_wr  = lk_wr  | (match[i] & wr_q[i]);
    end
  end

  assign lk_hit = |match;
  assign vld_o  = vld_q;
endmodule

// File: rtl/iova_victim.sv
module iova_victim #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  vld,
  input  logic          fill_en,
  output logic [IW-1:0] victim
);
  logic [IW-1:0] rr_q, rr_d;
  logic          any_free;

  always_comb begin
    victim   = rr_q;
    any_free = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        victim   = IW'(i);
        any_free = 1'b1;
      end
    end
  end

  always_comb begin
    rr_d = rr_q;
    if (fill_en && !any_free)
      rr_d = (rr_q == IW'(N - 1)) ? '0 : rr_q + IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end
endmodule

// File: rtl/iova_walker.sv
module iova_walker
  import iova_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VA_W-1:0]   st_vaddr,
  input  logic              st_write,
  input  logic [PA_W-1:0]   cfg_base,
  input  logic [SZ_W-1:0]   cfg_log2,
  input  logic              mem_ack,
  input  logic [DESC_W-1:0] mem_data,
  output logic              busy,
  output logic [PA_W-1:0]   mem_addr,
  output logic              done,
  output logic              fault,
  output logic [PPN_W-1:0]  ppn,
  output logic              wr_ok,
  output logic [VPN_W-1:0]  vpn,
  output logic [PG_SH-1:0]  off
);
  wk_state_e        st_q, st_d;
  logic [VA_W-1:0]  va_q;
  logic             we_q;
  logic [VPN_W-1:0] msk, idx;
  logic             d_valid;

  always_comb begin
    st_d = st_q;
    case (st_q)
      WK_IDLE:  if (start)   st_d = WK_FETCH;
      WK_FETCH: if (mem_ack) st_d = WK_IDLE;
      default:               st_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= WK_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (start && (st_q == WK_IDLE)) begin
      va_q <= st_vaddr;
      we_q <= st_write;
    end
  end

  assign vpn = va_q[VA_W-1:PG_SH];
  assign off = va_q[PG_SH-1:0];

  always_comb begin
    if (int'(cfg_log2) >= VPN_W) msk = '1;
    else                         msk = (VPN_W'(1) << cfg_log2) - VPN_W'(1);
    idx = vpn & msk;
  end

  assign mem_addr = cfg_base + PA_W'({idx, 3'b000});
  assign busy     = (st_q == WK_FETCH);
  assign done     = busy && mem_ack;
  assign d_valid  = mem_data[DESC_V];
  assign wr_ok    = mem_data[DESC_W_BIT];
  assign ppn      = mem_data[PPN_W-1:0];
  assign fault    = !d_valid || (we_q && !wr_ok);
endmodule

// File: rtl/iova_xlate.sv
module iova_xlate
  import iova_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int IW   = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_fault,
  output logic              mem_req,
  output logic [PA_W-1:0]   mem_addr,
  input  logic              mem_ack,
  input  logic [DESC_W-1:0] mem_data,
  input  logic [PA_W-1:0]   cfg_tbl_base,
  input  logic [SZ_W-1:0]   cfg_tbl_log2,
  input  logic              inval_all
);
  logic             accept, lk_hit, lk_wr;
  logic [PPN_W-1:0] lk_ppn;
  logic [N_ENT-1:0] slot_vld;
  logic [IW-1:0]    victim;
  logic             wk_busy, wk_done, wk_fault, wk_wr;
  logic [PPN_W-1:0] wk_ppn;
  logic [VPN_W-1:0] wk_vpn;
  logic [PG_SH-1:0] wk_off;
  logic             fill_en;
  logic             rv_d, fl_d;
  logic [PA_W-1:0]  pa_d;

  assign req_ready = !wk_busy;
  assign accept    = req_valid && req_ready;
  assign fill_en   = wk_done && !wk_fault;
  assign mem_req   = wk_busy;

  iova_cam #(.N(N_ENT)) u_cam (
    .clk, .rst_n,
    .lk_vpn   (req_vaddr[VA_W-1:PG_SH]),
    .lk_hit, .lk_ppn, .lk_wr,
    .fill_en,
    .fill_idx (victim),
    .fill_vpn (wk_vpn),
    .fill_ppn (wk_ppn),
    .fill_wr  (wk_wr),
    .inval_all,
    .vld_o    (slot_vld)
  );

  iova_victim #(.N(N_ENT)) u_vic (
    .clk, .rst_n,
    .vld     (slot_vld),
    .fill_en,
    .victim
  );

  iova_walker u_walk (
    .clk, .rst_n,
    .start    (accept && !lk_hit),
    .st_vaddr (req_vaddr),
    .st_write (req_write),
    .cfg_base (cfg_tbl_base),
    .cfg_log2 (cfg_tbl_log2),
    .mem_ack, .mem_data,
    .busy     (wk_busy),
    .mem_addr,
    .done     (wk_done),
    .fault    (wk_fault),
    .ppn      (wk_ppn),
    .wr_ok    (wk_wr),
    .vpn      (wk_vpn),
    .off      (wk_off)
  );

  always_comb begin
    rv_d = 1'b0;
    fl_d = 1'b0;
    pa_d = '0;
    if (accept && lk_hit) begin
      rv_d = 1'b1;
      if (req_write && !lk_wr) fl_d = 1'b1;
      else                     pa_d = {lk_ppn, req_vaddr[PG_SH-1:0]};
    end else if (wk_done) begin
      rv_d = 1'b1;
      if (wk_fault) fl_d = 1'b1;
      else          pa_d = {wk_ppn, wk_off};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= rv_d;
      rsp_fault <= fl_d;
      if (rv_d) rsp_paddr <= pa_d;
    end
  end
endmodule

// File: rtl/iova_xlate_chk.sv
module iova_xlate_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         req_ready,
  input logic [31:0]  req_vaddr,
  input logic         rsp_valid,
  input logic [33:0]  rsp_paddr,
  input logic         rsp_fault,
  input logic         mem_req,
  input logic [33:0]  mem_addr,
  input logic         mem_ack,
  input logic         inval_all,
  input logic [N-1:0] vld
);
  a_r5_stall_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  a_r4_fetch_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  a_r11_rsp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(req_valid && req_ready) || $past(mem_req && mem_ack)));

  a_r11_accept_resolves: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_valid || !req_ready));

  a_r10_inval_empties: assert property (@(posedge clk) disable iff (!rst_n)
    inval_all |=> (vld == '0));

  a_r6_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_valid && rsp_paddr == '0));

  a_r2_hit_offset: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid && req_ready) && rsp_valid && !rsp_fault)
      |-> (rsp_paddr[12:0] == $past(req_vaddr[12:0])));
endmodule

bind iova_xlate iova_xlate_chk #(.N(N_ENT)) u_chk (
  .clk, .rst_n, .req_valid, .req_ready, .req_vaddr,
  .rsp_valid, .rsp_paddr, .rsp_fault,
  .mem_req, .mem_addr, .mem_ack, .inval_all,
  .vld (slot_vld)
);

// File: tb/iova_xlate_bench.sv
`timescale 1ns/1ps
module iova_xlate_bench;
  localparam logic [33:0] BASE = 34'h2_4000_0000;
  localparam int          LOG2 = 6;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_vaddr;
  logic        rsp_valid, rsp_fault;
  logic [33:0] rsp_paddr;
  logic        mem_req, mem_ack;
  logic [33:0] mem_addr;
  logic [63:0] mem_data;
  logic        inval_all;

  int n_chk, n_fail, fetch_cnt, exp_fetch;
  logic [18:0] cur_vpn;
  logic [34:0] exp_q [$];

  function automatic logic [63:0] tbl(input int idx);
    logic [63:0] e;
    e        = '0;
    e[63]    = (idx != 5) && (idx != 40);
    e[62]    = (idx % 2 == 0);
    e[20:0]  = 21'h12000 + 21'(idx * 37);
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  iova_xlate u_iova_xlate (
    .clk, .rst_n, .req_valid, .req_ready, .req_vaddr, .req_write,
    .rsp_valid, .rsp_paddr, .rsp_fault, .mem_req, .mem_addr, .mem_ack,
    .mem_data, .cfg_tbl_base(BASE), .cfg_tbl_log2(5'(LOG2)), .inval_all
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // memory model: fixed latency, one acknowledge per read
  bit mbusy;
  int mcnt;
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0; mbusy = 0; mem_data = '0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req && !mbusy) begin
      mbusy = 1; mcnt = 2;
      chk(mem_addr == BASE + 34'({(cur_vpn & 19'd63), 3'b000}), "R4",
          "descriptor address", mem_addr, BASE + 34'({(cur_vpn & 19'd63), 3'b000}));
    end else if (mbusy) begin
      mcnt--;
      if (mcnt == 0) begin
        mem_data = tbl(int'((mem_addr - BASE) >> 3) & 63);
        mem_ack  = 1'b1;
        mbusy    = 0;
        fetch_cnt++;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk(0, "R11", "unexpected response", 1, 0);
      else begin
        logic [34:0] e;
        e = exp_q.pop_front();
        chk({rsp_fault, rsp_paddr} == e, "R2 R6 R7", "fault,paddr",
            {rsp_fault, rsp_paddr}, e);
      end
    end
  end

  task automatic send(input logic [18:0] vpn, input logic [12:0] off,
                      input logic wr, input bit miss, input string tag);
    logic [63:0] e;
    bit          f;
    e = tbl(int'(vpn & 19'd63));
    f = !e[63] || (wr && !e[62]);
    if (miss) exp_fetch++;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_vpn   = vpn;
    req_valid = 1'b1;
    req_vaddr = {vpn, off};
    req_write = wr;
    exp_q.push_back(f ? 35'h4_0000_0000 : {1'b0, e[20:0], off});
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == !miss, "R5", {tag, " ready after accept"}, req_ready, !miss);
    if (!miss) chk(rsp_valid == 1'b1, "R3", {tag, " hit latency"}, rsp_valid, 1);
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(fetch_cnt == exp_fetch, tag, "fetch count", fetch_cnt, exp_fetch);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog expired act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; fetch_cnt = 0; exp_fetch = 0; cur_vpn = '0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_vaddr = '0;
    inval_all = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
    chk(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);

    send(19'd1, 13'h123, 1'b0, 1, "R1 first miss");
    send(19'd1, 13'h1FFF, 1'b0, 0, "R3");
    send(19'd1, 13'h0004, 1'b1, 0, "R7 hit write ro");
    send(19'd2, 13'h0AA0, 1'b1, 1, "R2");
    send(19'd2, 13'h0000, 1'b1, 0, "R3");
    send(19'd3, 13'h0010, 1'b1, 1, "R7 fetch write ro");
    send(19'd3, 13'h0020, 1'b0, 1, "R7 not cached");
    send(19'd3, 13'h0030, 1'b0, 0, "R7 read ok");
    send(19'd5, 13'h0040, 1'b0, 1, "R6 invalid");
    send(19'd5, 13'h0050, 1'b0, 1, "R6 not cached");
    send(19'h41, 13'h0777, 1'b0, 1, "R4 alias");
    for (int v = 10; v <= 21; v++) send(19'(v), 13'(v * 5), 1'b0, 1, "R8 fill");
    send(19'd1, 13'h0001, 1'b0, 0, "R8");
    send(19'd2, 13'h0002, 1'b0, 0, "R8");
    send(19'd3, 13'h0003, 1'b0, 0, "R8");
    send(19'h41, 13'h0004, 1'b0, 0, "R8");
    for (int v = 10; v <= 21; v++) send(19'(v), 13'h1000, 1'b0, 0, "R8 resident");
    send(19'd30, 13'h0, 1'b0, 1, "R9 evict slot0");
    send(19'd31, 13'h0, 1'b0, 1, "R9 evict slot1");
    send(19'd3, 13'h0, 1'b0, 0, "R9 slot2 kept");
    send(19'd1, 13'h0, 1'b0, 1, "R9 evicted");
    send(19'h41, 13'h0, 1'b0, 0, "R9 slot3 kept");
    send(19'd2, 13'h0, 1'b0, 1, "R9 evicted");
    send(19'd3, 13'h0, 1'b0, 1, "R9 rotation");
    send(19'd11, 13'h0, 1'b0, 0, "R9 slot5 kept");

    @(negedge clk); inval_all = 1'b1;
    @(negedge clk); inval_all = 1'b0;
    send(19'h41, 13'h0, 1'b0, 1, "R10 after invalidate");
    send(19'd11, 13'h0, 1'b0, 1, "R10 after invalidate");
    send(19'd11, 13'h0, 1'b0, 0, "R10 refilled");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R11", "pending responses", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule